// File: doc/BRIEF.md
# Single-Cycle-Latency Transposed FIR Filter

This block is a finite impulse response filter that takes one signed sample per clock and returns one full-precision filtered sample per clock. It has only one register stage between a sample entering and the result that includes it leaving. That makes it usable inside a recursive loop, where the filter output at step k has to feed the input at step k+1. One example is the feedback half of a recursive filter built from two FIR sections.

The coefficients are fixed when the design is elaborated. They are given as a packed vector parameter, with tap 0 in the least significant field. Each tap multiplies the incoming sample by its constant coefficient. It adds the product to the registered partial sum of the tap above it and registers the result. These partial-sum registers are the only storage, so they also act as the sample delay line. There is no tapped shift register and no adder tree. The output is the partial sum of tap 0.

When the sample-valid input is low, every partial sum holds its value, so gaps in the input stream do not change the result. The default configuration has 25 taps with 8-bit coefficients and 8-bit signed samples. The default coefficients are 0, 10, 9, ..., 2, 1 on taps 0 to 10, and zero on all remaining taps.

Top module: `fir_transposed`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` = 0 and `out_data` = 0, and every partial sum is cleared.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge.
- R3: After an accepted sample x(k), the next cycle's `out_data` equals the sum over j of c(j)·x(k−j). Here x(k−j) is the j-th previously accepted sample, counting only samples accepted since the last reset, and samples before that count as zero.
- R4: With the default coefficients, an accepted sample of 10 followed by accepted zeros yields 0, 100, 90, 80, 70, 60, 50, 40, 30, 20, 10, 0 on consecutive cycles, with no extra leading zero.
- R5: A cycle with `in_valid` low leaves `out_data` unchanged and does not alter the stored history. The next accepted sample gives the same result it would have given without the gap.
- R6: `in_data` is two's complement. Results are exact, with no wrap, rounding or saturation, for every input including −128 and +127 held for many samples. `out_data` is two's complement and is XW+CW+ceil(log2(NTAPS)) bits wide.
- R7: A new sample is accepted on every cycle that `in_valid` is high, with no stall cycles in between.
- R8: After a reset in the middle of a stream, the first accepted sample x produces c(0)·x, so no earlier sample remains in the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_data` holds a sample to accept |
| in_data | input | XW | Signed input sample |
| out_valid | output | 1 | Registered flag: `in_valid` delayed by one clock |
| out_data | output | XW+CW+ceil(log2(NTAPS)) | Registered signed filter output |

## Verification
The assertions assume that `rst` is high for at least one edge before any check counts. They also assume that `in_data` is a plain signed byte, so the output bound is just the sum of coefficient magnitudes times 128. The stimulus keeps to this in three ways. Reset is raised before any sample. Every value drawn, whether from the full sweep of all 256 codes or from the random phase, stays inside the signed 8-bit range. The runs of −128 and +127 are long enough to fill every tap, so the extreme sums are actually reached.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // Width needed to hold an exact sum of NTAPS products of XW x CW bits
  function automatic int sum_width(input int xw, input int cw, input int ntaps);
    return xw + cw + $clog2(ntaps);
  endfunction

endpackage

// File: rtl/fir_tap.sv
// One stage of the transposed chain: constant multiply, add the upper
// partial sum, register. The register doubles as one sample of delay.
module fir_tap #(
  parameter int XW = 8,
  parameter int CW = 8,
  parameter int SW = 21,
  parameter logic signed [CW-1:0] COEF = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [XW-1:0] x,
  input  logic [SW-1:0] upper,
  output logic [SW-1:0] psum_q
);
  localparam int PW = XW + CW;

  logic signed [PW-1:0] prod;
  logic        [SW-1:0] prod_ext;
  logic        [SW-1:0] sum_d;

  always_comb begin
    prod     = $signed(x) * COEF;
    prod_ext = {{(SW-PW){prod[PW-1]}}, prod};
    sum_d    = prod_ext + upper;
  end

  always_ff @(posedge clk) begin
    if (rst)
      psum_q <= '0;
    else if (en)
      psum_q <= sum_d;
  end
endmodule

// File: rtl/fir_valid_reg.sv
// Registered sample-valid flag, aligned with the tap-0 register.
module fir_valid_reg (
  input  logic clk,
  input  logic rst,
  input  logic vin,
  output logic vout
);
  always_ff @(posedge clk) begin
    if (rst)
      vout <= 1'b0;
    else
      vout <= vin;
  end
endmodule

// File: rtl/fir_transposed.sv
module fir_transposed #(
  parameter int XW    = 8,
  parameter int CW    = 8,
  parameter int NTAPS = 25,
  // Tap i coefficient lives in COEF_VEC[i*CW +: CW]; tap 0 is the LSB field
  parameter logic [NTAPS*CW-1:0] COEF_VEC = {
    8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0,
    8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0,
    8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7,
    8'd8, 8'd9, 8'd10, 8'd0 }
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         in_valid,
  input  logic [XW-1:0]                                in_data,
  output logic                                         out_valid,
  output logic [fir_pkg::sum_width(XW, CW, NTAPS)-1:0] out_data
);
  localparam int SW = fir_pkg::sum_width(XW, CW, NTAPS);

  // psum[i] is the registered partial sum of tap i; psum[NTAPS] is the
  // constant zero that feeds the top of the chain.
  logic [SW-1:0] psum [NTAPS+1];

  assign psum[NTAPS] = '0;

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    fir_tap #(
      .XW  (XW),
      .CW  (CW),
      .SW  (SW),
      .COEF(COEF_VEC[i*CW +: CW])
    ) u_tap (
      .clk   (clk),
      .rst   (rst),
      .en    (in_valid),
      .x     (in_data),
      .upper (psum[i+1]),
      .psum_q(psum[i])
    );
  end

  fir_valid_reg u_vld (
    .clk (clk),
    .rst (rst),
    .vin (in_valid),
    .vout(out_valid)
  );

  assign out_data = psum[0];
endmodule

// File: rtl/fir_checker.sv
module fir_checker #(
  parameter int XW    = 8,
  parameter int CW    = 8,
  parameter int NTAPS = 25,
  parameter logic [NTAPS*CW-1:0] COEF_VEC = '0
) (
  input logic                                         clk,
  input logic                                         rst,
  input logic                                         in_valid,
  input logic [XW-1:0]                                in_data,
  input logic                                         out_valid,
  input logic [fir_pkg::sum_width(XW, CW, NTAPS)-1:0] out_data
);
  function automatic longint mag_sum();
    longint acc = 0;
    for (int i = 0; i < NTAPS; i++) begin
      longint c = longint'($signed(COEF_VEC[i*CW +: CW]));
      acc += (c < 0) ? -c : c;
    end
    return acc;
  endfunction

  localparam longint BOUND = mag_sum() * (longint'(1) << (XW - 1));

  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  // R1: reset clears the output register and flag
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R2: output flag follows the input flag one clock later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !in_valid |=> !out_valid);

  // R5: an idle cycle leaves the output untouched
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !in_valid |=> $stable(out_data));

  // R6: exact results can never exceed the coefficient magnitude bound
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (longint'($signed(out_data)) <= BOUND) && (longint'($signed(out_data)) >= -BOUND));
endmodule

bind fir_transposed fir_checker #(
  .XW(XW), .CW(CW), .NTAPS(NTAPS), .COEF_VEC(COEF_VEC)
) u_chk (.*);

// File: tb/tb_fir_transposed.sv
module tb_fir_transposed;
  localparam int XW = 8;
  localparam int CW = 8;
  localparam int NTAPS = 25;
  localparam int SW = XW + CW + $clog2(NTAPS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [XW-1:0] in_data = '0;
  logic          out_valid;
  logic [SW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  longint hist [NTAPS];
  longint last_out = 0;

  always #2 clk = ~clk;   // 250 MHz

  fir_transposed dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint coef(input int i);
    return (i >= 1 && i <= 10) ? longint'(11 - i) : 0;
  endfunction

  function automatic longint model();
    longint acc = 0;
    for (int j = 0; j < NTAPS; j++) acc += coef(j) * hist[j];
    return acc;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; drives, passes one rising edge, samples 1 ns later.
  task automatic step(input logic v, input int x, input string req);
    longint exp;
    in_valid = v;
    in_data  = XW'(x);
    @(posedge clk);
    #1;
    if (v) begin
      for (int j = NTAPS - 1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = longint'(x);
    end
    exp = v ? model() : last_out;
    check("R2", longint'(out_valid), longint'(v));
    check(req, longint'($signed(out_data)), exp);
    last_out = longint'($signed(out_data));
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = 8'h55;
    repeat (2) @(posedge clk);
    #1;
    check("R1", longint'(out_valid), 0);
    check("R1", longint'($signed(out_data)), 0);
    for (int j = 0; j < NTAPS; j++) hist[j] = 0;
    last_out = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R4: impulse of 10 produces the scaled response, no extra leading zeros
    step(1'b1, 10, "R4");
    check("R4", last_out, 0);
    for (int k = 1; k <= 11; k++) begin
      step(1'b1, 0, "R4");
      check("R4", last_out, (k <= 10) ? longint'(10 * (11 - k)) : 0);
    end

    // R3, R7: back-to-back sweep of every input code
    for (int v = -128; v < 128; v++) step(1'b1, v, "R3");

    // R6: sustained extremes fill every tap
    for (int k = 0; k < 30; k++) step(1'b1, -128, "R6");
    check("R6", last_out, -128 * 55);
    for (int k = 0; k < 30; k++) step(1'b1, 127, "R6");
    check("R6", last_out, 127 * 55);

    // R5: random stream with gaps
    for (int k = 0; k < 3000; k++) begin
      logic v = ($urandom % 3) != 0;
      int x = int'($urandom % 256) - 128;
      step(v, x, "R5");
    end

    // R8: mid-stream reset drops all history
    for (int k = 0; k < 5; k++) step(1'b1, 77, "R3");
    do_reset();
    step(1'b1, 5, "R8");
    check("R8", last_out, 0);
    step(1'b1, 5, "R8");
    check("R8", last_out, 50);
    step(1'b0, 0, "R5");
    check("R5", last_out, 50);
    step(1'b1, -3, "R8");
    check("R8", last_out, 5 * 10 + 5 * 9 - 3 * 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule